// File: doc/BRIEF.md
# Interrupt Cause and Mask Register Bank

This block gathers up to thirty-two interrupt sources into one cause vector and raises a single interrupt line whenever any cause bit is set and not masked. Software reaches it through a plain word-wide register port with address, write strobe, write data, read strobe and read data. One copy of the bank is placed for each interrupt group of a larger device, for example transmit, receive and miscellaneous events.

A source sets its cause bit in every cycle that its input is high, so level and pulse sources are both handled. Software may also force cause bits. Software acknowledges cause bits in one of two ways, and the choice is made per bit in a control word. In write-one-to-clear style, software writes a 1 to the bit. In clear-on-read style, reading the bit clears it. The mask can be loaded as a whole word, or changed with separate set and clear aliases so that concurrent agents need no read-modify-write. A hardware event always wins over an acknowledge in the same cycle, so no event is lost.

The register word index is taken from address bits [4:2]. Bits [1:0] are ignored. Any higher address bit that is set selects no register.

Top module: `irq_cause_bank`

## Requirements
- R1: After a synchronous active-low reset, the following hold:
  - The control word (0x00) reads 0, so every bit is write-one-to-clear.
  - The cause (0x04) reads 0.
  - The mask (0x10) reads all ones.
  - `irq_out` is 0.
- R2: A high `src_evt[i]` sets cause bit i at the next clock edge. If an acknowledge of bit i falls in the same cycle as the event, the bit stays set.
- R3: Writing 1s to the force word (0x0C) sets the matching cause bits. The force word reads back as 0.
- R4: When control bit i is 0, bit i is write-one-to-clear:
  - Writing 1 at bit i of the cause (0x04) or of the masked cause (0x08) clears cause bit i.
  - Writing 0 leaves the bit unchanged.
  - Reading does not clear it.
- R5: When control bit i is 1, bit i is clear-on-read:
  - A read of the cause (0x04) returns bit i and then clears it.
  - Writes to the cause or masked cause leave the bit unchanged.
- R6: When control bit i is 1, a read of the masked cause (0x08) clears cause bit i only if mask bit i is 0. A masked bit stays set.
- R7: The masked cause (0x08) reads as cause AND NOT mask.
- R8: The mask is changed through three words, all acting at bit position i:
  - A write to 0x10 loads it.
  - A write to 0x14 ORs the written 1s into it.
  - A write to 0x18 clears the bits written as 1.
  - 0x14 and 0x18 read back as 0.
- R9: `irq_out` is registered. In the cycle after any bit of cause AND NOT mask is 1, it is 1. Otherwise it is 0.
- R10: Read data is registered. It shows the selected word after the clock edge on which `bus_rd` is high, and holds until the next read. Word 0x1C and any address at or above 0x20 read 0.
- R11: Each cause bit uses its own control bit. In one control word, some bits can be clear-on-read while the others are write-one-to-clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_evt | input | NUM_SRC | Hardware interrupt sources, one per cause bit |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Registered read data |
| irq_out | output | 1 | Registered interrupt request |

## Verification
Two pairs of functions can coincide in one cycle.

The first pair is a hardware event and a software acknowledge of the same bit. The bench raises `src_evt` in the same cycle as a write-one-to-clear of that bit, and also holds a level source high across an acknowledge. It then reads the cause back and expects the bit to still be set.

The second pair is a clear-on-read of the masked cause and the mask itself. The bench reads the masked cause while some pending bits are masked and some are not. A later cause read must show that only the visible bits were cleared.

// File: rtl/icb_pkg.sv
// Package: shared register indices and decoded-select type for the
// interrupt cause bank. Assumes word-aligned registers, index in addr[4:2].
package icb_pkg;

    typedef enum logic [2:0] {
        IDX_CTRL   = 3'd0,
        IDX_CAUSE  = 3'd1,
        IDX_MCAUSE = 3'd2,
        IDX_FORCE  = 3'd3,
        IDX_MASK   = 3'd4,
        IDX_MSET   = 3'd5,
        IDX_MCLR   = 3'd6,
        IDX_SPARE  = 3'd7
    } icb_idx_e;

    typedef struct packed {
        logic ctrl;
        logic cause;
        logic mcause;
        logic force_w;
        logic mask;
        logic mset;
        logic mclr;
    } icb_sel_t;

    localparam int IDX_LSB = 2;
    localparam int IDX_MSB = 4;

endpackage

// File: rtl/icb_addr_dec.sv
// Module: icb_addr_dec
// Turns a byte address into a one-hot register select. Bits [1:0] are
// ignored; any set bit above bit 4 selects nothing. Assumes ADDR_W > 5.
module icb_addr_dec
    import icb_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output icb_sel_t          sel
);

    localparam int HI_W = ADDR_W - IDX_MSB - 1;

    logic     in_range;
    icb_idx_e idx;

    // Purpose: check that the address falls inside the bank window.
    always_comb in_range = (addr[ADDR_W-1:IDX_MSB+1] == HI_W'(0));

    // Purpose: extract the word index.
    always_comb idx = icb_idx_e'(addr[IDX_MSB:IDX_LSB]);

    // Purpose: one-hot select of the addressed register.
    always_comb begin
        sel = '0;
        if (in_range) begin
            case (idx)
                IDX_CTRL:   sel.ctrl    = 1'b1;
                IDX_CAUSE:  sel.cause   = 1'b1;
                IDX_MCAUSE: sel.mcause  = 1'b1;
                IDX_FORCE:  sel.force_w = 1'b1;
                IDX_MASK:   sel.mask    = 1'b1;
                IDX_MSET:   sel.mset    = 1'b1;
                IDX_MCLR:   sel.mclr    = 1'b1;
                default:    sel         = '0;
            endcase
        end
    end

endmodule

// File: rtl/icb_mask_ctrl.sv
// Module: icb_mask_ctrl
// Holds the per-bit acknowledge control word and the mask. The mask is
// loaded whole, or bit-set / bit-cleared through its aliases. Assumes at
// most one select is active per cycle (guaranteed by the decoder).
module icb_mask_ctrl
    import icb_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  icb_sel_t           sel,
    input  logic [NUM_SRC-1:0] wd,
    output logic [NUM_SRC-1:0] ctrl_q,
    output logic [NUM_SRC-1:0] mask_q
);

    // Purpose: control word; 0 = write-one-to-clear, 1 = clear-on-read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (wr && sel.ctrl)
            ctrl_q <= wd;
    end

    // Purpose: mask register with direct load and set/clear aliases.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '1;
        else if (wr && sel.mask)
            mask_q <= wd;
        else if (wr && sel.mset)
            mask_q <= mask_q | wd;
        else if (wr && sel.mclr)
            mask_q <= mask_q & ~wd;
    end

    a_r8_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel.mask) |=> (mask_q == $past(wd)));

    a_r8_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel.mset) |=> ((mask_q & $past(wd)) == $past(wd)));

    a_r8_mask_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel.mclr) |=> ((mask_q & $past(wd)) == '0));

endmodule

// File: rtl/icb_cause_vec.sv
// Module: icb_cause_vec
// Cause bits. Each bit is set by its hardware source or by a software force
// write, and cleared by the acknowledge style its control bit selects. A set
// in the same cycle as a clear wins.
module icb_cause_vec
    import icb_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_evt,
    input  logic               wr,
    input  logic               rd,
    input  icb_sel_t           sel,
    input  logic [NUM_SRC-1:0] wd,
    input  logic [NUM_SRC-1:0] ctrl,
    input  logic [NUM_SRC-1:0] mask,
    output logic [NUM_SRC-1:0] cause_q
);

    logic [NUM_SRC-1:0] set_v;
    logic [NUM_SRC-1:0] wclr_v;
    logic [NUM_SRC-1:0] rclr_v;
    logic [NUM_SRC-1:0] clr_v;

    // Purpose: gather set requests from hardware and force writes.
    always_comb set_v = src_evt | ({NUM_SRC{wr & sel.force_w}} & wd);

    // Purpose: write-one-to-clear requests on bits in that style.
    always_comb wclr_v = {NUM_SRC{wr & (sel.cause | sel.mcause)}} & wd & ~ctrl;

    // Purpose: clear-on-read requests; a masked-cause read clears only visible bits.
    always_comb rclr_v = ctrl & ({NUM_SRC{rd & sel.cause}} |
                                 ({NUM_SRC{rd & sel.mcause}} & ~mask));

    // Purpose: merge both clear paths.
    always_comb clr_v = wclr_v | rclr_v;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        // Purpose: one cause flop, with set priority over clear.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cause_q[i] <= 1'b0;
            else if (set_v[i])
                cause_q[i] <= 1'b1;
            else if (clr_v[i])
                cause_q[i] <= 1'b0;
        end

        a_r2_evt_sets: assert property (@(posedge clk) disable iff (!rst_n)
            src_evt[i] |=> cause_q[i]);

        a_r4_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (wr && (sel.cause || sel.mcause) && wd[i] && !ctrl[i] &&
             !src_evt[i]) |=> !cause_q[i]);

        a_r5_cor_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (rd && sel.cause && ctrl[i] && !src_evt[i] &&
             !(wr && sel.force_w && wd[i])) |=> !cause_q[i]);

        a_r6_masked_kept: assert property (@(posedge clk) disable iff (!rst_n)
            (rd && sel.mcause && ctrl[i] && mask[i] && cause_q[i]) |=> cause_q[i]);
    end

endmodule

// File: rtl/icb_rd_mux.sv
// Module: icb_rd_mux
// Registered read-data path. Write-only words, the spare slot and
// out-of-window addresses return zero. Data holds between reads.
module icb_rd_mux
    import icb_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd,
    input  icb_sel_t           sel,
    input  logic [NUM_SRC-1:0] ctrl,
    input  logic [NUM_SRC-1:0] cause,
    input  logic [NUM_SRC-1:0] mask,
    output logic [DATA_W-1:0]  rdata_q
);

    logic [NUM_SRC-1:0] pick;
    logic [DATA_W-1:0]  word;

    // Purpose: choose the readable register for the selected word.
    always_comb begin
        pick = '0;
        if (sel.ctrl)   pick = ctrl;
        if (sel.cause)  pick = cause;
        if (sel.mcause) pick = cause & ~mask;
        if (sel.mask)   pick = mask;
    end

    // Purpose: zero-extend the picked value to the bus width.
    always_comb begin
        word = '0;
        word[NUM_SRC-1:0] = pick;
    end

    // Purpose: capture read data on a read strobe, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (rd)
            rdata_q <= word;
    end

    a_r10_wo_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && (sel.force_w || sel.mset || sel.mclr)) |=> (rdata_q == '0));

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(rdata_q));

endmodule

// File: rtl/irq_cause_bank.sv
// Module: irq_cause_bank (top)
// Interrupt cause/mask register bank for one interrupt group. It joins the
// decoder, the mask/control registers, the cause vector and the read path,
// and registers the OR of the unmasked causes onto irq_out.
// Assumes NUM_SRC <= DATA_W and ADDR_W > 5.
module irq_cause_bank
    import icb_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_evt,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic               bus_rd,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               irq_out
);

    icb_sel_t           sel;
    logic [NUM_SRC-1:0] wd;
    logic [NUM_SRC-1:0] ctrl_q;
    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] cause_q;
    logic               irq_q;

    // Purpose: narrow write data to the implemented sources.
    always_comb wd = bus_wdata[NUM_SRC-1:0];

    icb_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    icb_mask_ctrl #(.NUM_SRC(NUM_SRC)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (bus_wr),
        .sel    (sel),
        .wd     (wd),
        .ctrl_q (ctrl_q),
        .mask_q (mask_q)
    );

    icb_cause_vec #(.NUM_SRC(NUM_SRC)) u_cause (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_evt (src_evt),
        .wr      (bus_wr),
        .rd      (bus_rd),
        .sel     (sel),
        .wd      (wd),
        .ctrl    (ctrl_q),
        .mask    (mask_q),
        .cause_q (cause_q)
    );

    icb_rd_mux #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd      (bus_rd),
        .sel     (sel),
        .ctrl    (ctrl_q),
        .cause   (cause_q),
        .mask    (mask_q),
        .rdata_q (bus_rdata)
    );

    // Purpose: registered interrupt request from the unmasked causes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else
            irq_q <= |(cause_q & ~mask_q);
    end

    assign irq_out = irq_q;

    a_r9_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (|(cause_q & ~mask_q)) |=> irq_out);

    a_r9_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(cause_q & ~mask_q)) |=> !irq_out);

endmodule

// File: tb/irq_cause_bank_test.sv
// Directed bench for irq_cause_bank: one task per scenario.
module irq_cause_bank_test;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] A_CTRL = 8'h00, A_CAUSE = 8'h04, A_MCAUSE = 8'h08,
                           A_FORCE = 8'h0C, A_MASK = 8'h10, A_MSET = 8'h14,
                           A_MCLR = 8'h18, A_SPARE = 8'h1C, A_OUT = 8'h24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_evt = '0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        irq_out;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_cause_bank uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_evt   (src_evt),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic clean(input logic [31:0] m);
        wr_reg(A_CTRL, 32'h0);
        wr_reg(A_CAUSE, 32'hFFFF_FFFF);
        wr_reg(A_MASK, m);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1", "irq after reset", {31'b0, irq_out}, 32'h0);
        rd_reg(A_CTRL, d);  chk("R1", "ctrl reset", d, 32'h0);
        rd_reg(A_CAUSE, d); chk("R1", "cause reset", d, 32'h0);
        rd_reg(A_MASK, d);  chk("R1", "mask reset", d, 32'hFFFF_FFFF);
    endtask

    task automatic t_hw_event();
        logic [31:0] d;
        clean(32'hFFFF_FFFF);
        @(negedge clk); src_evt = 32'h0000_0005;
        @(negedge clk); src_evt = '0;
        rd_reg(A_CAUSE, d); chk("R2", "pulse sets cause", d, 32'h0000_0005);
        chk("R9", "masked event keeps irq low", {31'b0, irq_out}, 32'h0);
        // R2: event and W1C acknowledge of the same bit in the same cycle
        wr_reg(A_FORCE, 32'h0000_0008);
        @(negedge clk);
        src_evt = 32'h0000_0008; bus_addr = A_CAUSE; bus_wdata = 32'h8; bus_wr = 1'b1;
        @(negedge clk);
        src_evt = '0; bus_wr = 1'b0;
        rd_reg(A_CAUSE, d); chk("R2", "event wins over clear", d & 32'h8, 32'h8);
        // R2: level source held across an acknowledge
        @(negedge clk); src_evt = 32'h0000_0040;
        wr_reg(A_CAUSE, 32'h0000_0040);
        rd_reg(A_CAUSE, d); chk("R2", "level source survives ack", d & 32'h40, 32'h40);
        src_evt = '0;
    endtask

    task automatic t_force();
        logic [31:0] d;
        clean(32'hFFFF_FFFF);
        wr_reg(A_FORCE, 32'h00F0_0000);
        rd_reg(A_CAUSE, d); chk("R3", "force sets cause", d, 32'h00F0_0000);
        rd_reg(A_FORCE, d); chk("R3", "force reads zero", d, 32'h0);
    endtask

    task automatic t_w1c();
        logic [31:0] d;
        clean(32'hFFFF_FFFF);
        wr_reg(A_FORCE, 32'h0000_0F0F);
        wr_reg(A_CAUSE, 32'h0);
        rd_reg(A_CAUSE, d); chk("R4", "write 0 no effect", d, 32'h0000_0F0F);
        rd_reg(A_CAUSE, d); chk("R4", "read does not clear", d, 32'h0000_0F0F);
        wr_reg(A_MCAUSE, 32'h0000_0003);
        rd_reg(A_CAUSE, d); chk("R4", "W1C via masked cause", d, 32'h0000_0F0C);
        wr_reg(A_CAUSE, 32'h0000_0F00);
        rd_reg(A_CAUSE, d); chk("R4", "W1C via cause", d, 32'h0000_000C);
    endtask

    task automatic t_cor();
        logic [31:0] d;
        clean(32'hFFFF_FFFF);
        wr_reg(A_CTRL, 32'hFFFF_FFFF);
        wr_reg(A_FORCE, 32'h0000_0003);
        rd_reg(A_CAUSE, d); chk("R5", "COR returns value", d, 32'h0000_0003);
        rd_reg(A_CAUSE, d); chk("R5", "COR cleared", d, 32'h0);
        wr_reg(A_FORCE, 32'h0000_0004);
        wr_reg(A_CAUSE, 32'h0000_0004);
        wr_reg(A_MCAUSE, 32'h0000_0004);
        rd_reg(A_CAUSE, d); chk("R5", "writes ignored in COR", d, 32'h0000_0004);
    endtask

    task automatic t_mcause();
        logic [31:0] d;
        clean(32'h0000_FFFF);
        wr_reg(A_CTRL, 32'hFFFF_FFFF);
        wr_reg(A_FORCE, 32'h0001_0001);
        rd_reg(A_MCAUSE, d); chk("R7", "masked cause value", d, 32'h0001_0000);
        rd_reg(A_CAUSE, d);  chk("R6", "masked bit kept, visible cleared", d, 32'h0000_0001);
        rd_reg(A_CAUSE, d);  chk("R6", "cause empty after reads", d, 32'h0);
    endtask

    task automatic t_mask();
        logic [31:0] d;
        wr_reg(A_MASK, 32'h1234_5678);
        rd_reg(A_MASK, d); chk("R8", "mask load", d, 32'h1234_5678);
        wr_reg(A_MSET, 32'h0000_000F);
        rd_reg(A_MASK, d); chk("R8", "mask set alias", d, 32'h1234_567F);
        wr_reg(A_MCLR, 32'h1000_0001);
        rd_reg(A_MASK, d); chk("R8", "mask clear alias", d, 32'h0234_567E);
        rd_reg(A_MSET, d); chk("R8", "mask set reads zero", d, 32'h0);
        rd_reg(A_MCLR, d); chk("R8", "mask clear reads zero", d, 32'h0);
    endtask

    task automatic t_irq();
        clean(32'hFFFF_FFFF);
        wr_reg(A_FORCE, 32'h0000_0200);
        chk("R9", "masked cause no irq", {31'b0, irq_out}, 32'h0);
        wr_reg(A_MCLR, 32'h0000_0200);
        chk("R9", "irq one cycle late", {31'b0, irq_out}, 32'h0);
        @(negedge clk);
        chk("R9", "irq raised", {31'b0, irq_out}, 32'h1);
        wr_reg(A_CAUSE, 32'h0000_0200);
        @(negedge clk);
        chk("R9", "irq dropped after ack", {31'b0, irq_out}, 32'h0);
    endtask

    task automatic t_mixed();
        logic [31:0] d;
        clean(32'hFFFF_FFFF);
        wr_reg(A_CTRL, 32'h0000_000F);
        wr_reg(A_FORCE, 32'h0000_00FF);
        rd_reg(A_CAUSE, d); chk("R11", "mixed first read", d, 32'h0000_00FF);
        rd_reg(A_CAUSE, d); chk("R11", "only COR bits cleared", d, 32'h0000_00F0);
        wr_reg(A_CAUSE, 32'h0000_00FF);
        rd_reg(A_CAUSE, d); chk("R11", "W1C bits cleared by write", d, 32'h0);
    endtask

    task automatic t_rdpath();
        logic [31:0] d;
        wr_reg(A_FORCE, 32'h0000_0010);
        rd_reg(A_SPARE, d); chk("R10", "spare word reads zero", d, 32'h0);
        rd_reg(A_CAUSE, d);
        @(negedge clk);
        chk("R10", "read data holds", bus_rdata, 32'h0000_0010);
        rd_reg(A_OUT, d); chk("R10", "out-of-window reads zero", d, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_hw_event();
        t_force();
        t_w1c();
        t_cor();
        t_mcause();
        t_mask();
        t_irq();
        t_mixed();
        t_rdpath();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule